// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare Flag

This block is a word-addressed, 32-bit down-counting timer for use as a memory-mapped peripheral. Five registers are mapped on a simple synchronous write port with a combinational read port. The registers hold the control settings, a status flag, the load value, the compare value and the live count. A two-bit control field routes one of three tick-enable inputs into the counter, or none. A 12-bit prescaler then passes one of every N+1 selected ticks.

On each divided tick the counter steps down by one. When it reaches zero it either reloads from the load register or wraps to all-ones, depending on a control bit. A divided tick on which the count equals the compare value raises a sticky status flag. Software clears the flag by writing a one to it. The interrupt output follows that flag, gated by the compare-interrupt enable and the timer enable.

Besides the asynchronous hard reset, a self-clearing software-reset control bit returns the timer registers to their initial values. It keeps the enable, the enable-mode bit and four low-power enable bits, which are stored but have no function here. When the timer is enabled, it can start from the load value or from all-ones. A load write can also replace the running count at once.

Top module: `cmp_down_timer`

## Requirements
- R1: Word offsets 0 to 4 select control, status, load, compare and count. Reading any other offset gives zero. Writes to offset 4 or to any unmapped offset change nothing.
- R2: A control write keeps bits [25:0]; bits [31:26] read as zero. Fields: EN bit 0, ENMOD bit 1, OCIEN bit 2, RLD bit 3, prescaler [15:4], SWR bit 16, IOVW bit 17, low-power enables bits 18 to 21, clock source [25:24].
- R3: Hard reset (rst_n low) gives control 0, status 0, load 0xFFFFFFFF, compare 0, count 0 and irq low.
- R4: A control write with bit 16 set stores the written value masked to bits 0, 1 and 18 to 21. Bit 16 always reads 0. The same write clears status and compare and sets load to 0xFFFFFFFF. The count becomes 0xFFFFFFFF if bit 0 was written as 1, and 0 otherwise.
- R5: Clock source 00 selects no tick (count frozen), 01 selects tickIn[0], 10 selects tickIn[1] and 11 selects tickIn[2]. Unselected inputs have no effect.
- R6: With prescaler value P, the count steps once per P+1 selected ticks. The prescale counter is held at zero while EN is 0.
- R7: On a divided tick the count decrements. At zero it takes the load value if RLD is 1, or 0xFFFFFFFF if RLD is 0.
- R8: A control write that sets EN from 0 while ENMOD is 1 starts the count at the load value if RLD is 1, or at 0xFFFFFFFF if RLD is 0. With ENMOD 0 the count keeps its old value.
- R9: While EN is 0 the count does not change, except through a load write with IOVW or a software reset.
- R10: A load write stores the value. If IOVW is 1 the count takes the written value on the next cycle, whatever RLD is. If IOVW is 0 the count is unaffected.
- R11: A divided tick on which count equals compare, with EN and OCIEN set, sets status bit 0. The bit stays set until it is cleared.
- R12: Writing status with bit 0 = 1 clears the flag, and this clear wins over a set in the same cycle. Writing bit 0 = 0 has no effect.
- R13: irq is high exactly when the flag, OCIEN and EN are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Word offset of the register |
| wrData | input | 32 | Write data |
| tickIn | input | 3 | Tick-enable inputs, one per clock source |
| rdData | output | 32 | Read data for regAddr (combinational) |
| irq | output | 1 | Compare interrupt |

## Verification
The bench drives the three tick inputs with unrelated patterns, so a wrong source decode or an off-by-one prescaler shows up as a count that drifts from the model. It checks the step at zero in both reload modes. A design that ignored RLD would reload when it should wrap to all-ones, or the other way round. It checks an enable with and without ENMOD, a load write with and without IOVW, and a soft reset with EN written as 1 and as 0; a design that got the keep-mask wrong would read back extra control bits. It checks the flag when the compare interrupt is disabled, a status write of zero, and EN dropped while the flag is set. In each case a wrong design would give a stray or missing irq.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int TMR_W = 32;
  localparam int CTRL_W = 26;
  localparam int PSC_W = 12;
  localparam int SRC_W = 2;

  localparam int BIT_EN = 0;
  localparam int BIT_ENMOD = 1;
  localparam int BIT_OCIEN = 2;
  localparam int BIT_RLD = 3;
  localparam int PSC_LSB = 4;
  localparam int BIT_SWR = 16;
  localparam int BIT_IOVW = 17;
  localparam int SRC_LSB = 24;

  localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h03C_0003;

  localparam logic [3:0] OFS_CTRL = 4'd0;
  localparam logic [3:0] OFS_STAT = 4'd1;
  localparam logic [3:0] OFS_LOAD = 4'd2;
  localparam logic [3:0] OFS_CMP = 4'd3;
  localparam logic [3:0] OFS_CNT = 4'd4;

  typedef struct packed {
    logic forceCount;
    logic [TMR_W-1:0] forceValue;
    logic clearPsc;
  } cdtStrobe_t;
endpackage

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  cdtStrobe_t strobes,
  input  logic run,
  input  logic matchEn,
  input  logic reloadOn,
  input  logic [SRC_W-1:0] clkSel,
  input  logic [PSC_W-1:0] prescale,
  input  logic [TMR_W-1:0] loadVal,
  input  logic [TMR_W-1:0] cmpVal,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic [TMR_W-1:0] cntVal,
  output logic matchEvt
);
  localparam int SEL_N = NUM_SRC + 1;

  logic [SEL_N-1:0] srcVec;
  logic selTick;
  logic divTick;
  logic [PSC_W-1:0] pscCnt;

  assign srcVec = {tickIn, 1'b0};
  assign selTick = srcVec[clkSel];
  assign divTick = run && selTick && (pscCnt == prescale);
  assign matchEvt = divTick && matchEn && (cntVal == cmpVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pscCnt <= '0;
    end else if (strobes.clearPsc || !run) begin
      pscCnt <= '0;
    end else if (selTick) begin
      pscCnt <= (pscCnt == prescale) ? '0 : pscCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal <= '0;
    end else if (strobes.forceCount) begin
      cntVal <= strobes.forceValue;
    end else if (divTick) begin
      if (cntVal == '0) cntVal <= reloadOn ? loadVal : '1;
      else cntVal <= cntVal - 1'b1;
    end
  end

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !strobes.forceCount) |=> $stable(cntVal));
  assert_zero_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (divTick && cntVal == '0 && !strobes.forceCount) |=>
      cntVal == ($past(reloadOn) ? $past(loadVal) : {TMR_W{1'b1}}));
  assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (divTick && cntVal != '0 && !strobes.forceCount) |=> cntVal == $past(cntVal) - 1'b1);
  assert_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.forceCount |=> cntVal == $past(strobes.forceValue));
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TMR_W-1:0] wrData,
  input  logic [TMR_W-1:0] cntVal,
  input  logic matchEvt,
  output logic [TMR_W-1:0] rdData,
  output logic irq,
  output cdtStrobe_t strobes,
  output logic run,
  output logic matchEn,
  output logic reloadOn,
  output logic [SRC_W-1:0] clkSel,
  output logic [PSC_W-1:0] prescale,
  output logic [TMR_W-1:0] loadVal,
  output logic [TMR_W-1:0] cmpVal
);
  logic [CTRL_W-1:0] ctrlReg;
  logic flag;
  logic wrCtrl, wrStat, wrLoad, wrCmp, wrSwr, enRise;

  assign wrCtrl = wrEn && (regAddr == ADDR_W'(OFS_CTRL));
  assign wrStat = wrEn && (regAddr == ADDR_W'(OFS_STAT));
  assign wrLoad = wrEn && (regAddr == ADDR_W'(OFS_LOAD));
  assign wrCmp  = wrEn && (regAddr == ADDR_W'(OFS_CMP));
  assign wrSwr  = wrCtrl && wrData[BIT_SWR];
  assign enRise = wrCtrl && !wrSwr && wrData[BIT_EN] && !ctrlReg[BIT_EN] && wrData[BIT_ENMOD];

  assign run = ctrlReg[BIT_EN];
  assign matchEn = ctrlReg[BIT_OCIEN];
  assign reloadOn = ctrlReg[BIT_RLD];
  assign clkSel = ctrlReg[SRC_LSB +: SRC_W];
  assign prescale = ctrlReg[PSC_LSB +: PSC_W];
  assign irq = flag && ctrlReg[BIT_OCIEN] && ctrlReg[BIT_EN];

  always_comb begin
    strobes.clearPsc = wrSwr;
    strobes.forceCount = wrSwr || enRise || (wrLoad && ctrlReg[BIT_IOVW]);
    if (wrSwr) strobes.forceValue = wrData[BIT_EN] ? '1 : '0;
    else if (enRise) strobes.forceValue = wrData[BIT_RLD] ? loadVal : '1;
    else strobes.forceValue = wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= wrSwr ? (wrData[CTRL_W-1:0] & KEEP_MASK) : wrData[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      loadVal <= '1;
      cmpVal <= '0;
    end else if (wrSwr) begin
      flag <= 1'b0;
      loadVal <= '1;
      cmpVal <= '0;
    end else begin
      if (wrStat && wrData[0]) flag <= 1'b0;
      else if (matchEvt) flag <= 1'b1;
      if (wrLoad) loadVal <= wrData;
      if (wrCmp) cmpVal <= wrData;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFS_CTRL): rdData = {{(TMR_W-CTRL_W){1'b0}}, ctrlReg};
      ADDR_W'(OFS_STAT): rdData = {{(TMR_W-1){1'b0}}, flag};
      ADDR_W'(OFS_LOAD): rdData = loadVal;
      ADDR_W'(OFS_CMP):  rdData = cmpVal;
      ADDR_W'(OFS_CNT):  rdData = cntVal;
      default:           rdData = '0;
    endcase
  end

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStat && wrData[0]) |=> !flag);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wrStat && !wrCtrl) |=> flag);
  assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrSwr |=> (loadVal == {TMR_W{1'b1}} && cmpVal == '0 && !flag && !ctrlReg[BIT_SWR]));
  assert_cmp_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCmp && !wrSwr) |=> cmpVal == $past(wrData));
endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_SRC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TMR_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] tickIn,
  output logic [TMR_W-1:0] rdData,
  output logic irq
);
  cdtStrobe_t strobes;
  logic run, matchEn, reloadOn, matchEvt;
  logic [SRC_W-1:0] clkSel;
  logic [PSC_W-1:0] prescale;
  logic [TMR_W-1:0] loadVal, cmpVal, cntVal;

  cdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .cntVal(cntVal), .matchEvt(matchEvt), .rdData(rdData), .irq(irq),
    .strobes(strobes), .run(run), .matchEn(matchEn), .reloadOn(reloadOn),
    .clkSel(clkSel), .prescale(prescale), .loadVal(loadVal), .cmpVal(cmpVal)
  );

  cdt_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .run(run), .matchEn(matchEn),
    .reloadOn(reloadOn), .clkSel(clkSel), .prescale(prescale), .loadVal(loadVal),
    .cmpVal(cmpVal), .tickIn(tickIn), .cntVal(cntVal), .matchEvt(matchEvt)
  );
endmodule

// File: tb/tb_cmp_down_timer.sv
module tb_cmp_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_EN = 32'h1, C_ENMOD = 32'h2, C_OCIEN = 32'h4, C_RLD = 32'h8;
  localparam logic [31:0] C_SWR = 32'h1_0000, C_IOVW = 32'h2_0000, C_STOPEN = 32'h20_0000;
  localparam logic [31:0] C_DBGEN = 32'h4_0000;

  logic clk = 0, rst_n = 0, wrEn = 0;
  logic [3:0] regAddr = 4'd4;
  logic [31:0] wrData = 0;
  logic [2:0] tickIn = 3'b000;
  logic [31:0] rdData;
  logic irq;
  int checks = 0, errors = 0, cyc = 0;
  string curReq = "R3";
  bit done = 0;

  logic [31:0] mCtrl, mLoad, mCmp, mCnt, nCnt;
  logic mFlag, st, dt, hit, mEn;
  int mPsc, nPsc, pre;

  cmp_down_timer dut (.clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .tickIn(tickIn), .rdData(rdData), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return mCtrl;
      4'd1: return {31'b0, mFlag};
      4'd2: return mLoad;
      4'd3: return mCmp;
      4'd4: return mCnt;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCtrl = 0; mFlag = 0; mLoad = 32'hFFFF_FFFF; mCmp = 0; mCnt = 0; mPsc = 0;
    end else begin
      mEn = mCtrl[0];
      pre = int'(mCtrl[15:4]);
      case (mCtrl[25:24])
        2'd1: st = tickIn[0];
        2'd2: st = tickIn[1];
        2'd3: st = tickIn[2];
        default: st = 1'b0;
      endcase
      dt = mEn && st && (mPsc == pre);
      hit = dt && mCtrl[2] && (mCnt == mCmp);
      nCnt = mCnt;
      if (dt) nCnt = (mCnt == 0) ? (mCtrl[3] ? mLoad : 32'hFFFF_FFFF) : mCnt - 1;
      nPsc = !mEn ? 0 : (st ? ((mPsc == pre) ? 0 : mPsc + 1) : mPsc);
      if (hit) mFlag = 1;
      if (wrEn) begin
        case (regAddr)
          4'd0: if (wrData[16]) begin
                  mCtrl = wrData & 32'h003C_0003; mFlag = 0; mLoad = 32'hFFFF_FFFF;
                  mCmp = 0; nCnt = wrData[0] ? 32'hFFFF_FFFF : 0; nPsc = 0;
                end else begin
                  if (wrData[0] && !mCtrl[0] && wrData[1])
                    nCnt = wrData[3] ? mLoad : 32'hFFFF_FFFF;
                  mCtrl = wrData & 32'h03FF_FFFF;
                end
          4'd1: if (wrData[0]) mFlag = 0;
          4'd2: begin if (mCtrl[17]) nCnt = wrData; mLoad = wrData; end
          4'd3: mCmp = wrData;
          default: ;
        endcase
      end
      mCnt = nCnt; mPsc = nPsc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // every-cycle comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(curReq, rdData, mRead(regAddr));
      chk({curReq, " R13 irq"}, {31'b0, irq}, {31'b0, mFlag && mCtrl[2] && mCtrl[0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wrEn = 0; regAddr = 4'd4;
      case (pat)
        0: tickIn = 3'b000;
        1: tickIn = 3'b111;
        default: tickIn = {(cyc % 5) == 0, (cyc % 3) != 0, (cyc % 2) == 0};
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    wrEn = 1; regAddr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 0; regAddr = 4'd4;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(posedge clk); #2;
    wrEn = 0; regAddr = a;
    @(negedge clk); #1;
    chk(req, rdData, exp);
  endtask

  initial begin
    step(3, 0);
    @(posedge clk); #2; rst_n = 1;
    curReq = "R3";
    rd("R3 ctrl", 4'd0, 32'h0);
    rd("R3 status", 4'd1, 32'h0);
    rd("R3 load", 4'd2, 32'hFFFF_FFFF);
    rd("R3 cmp", 4'd3, 32'h0);
    rd("R3 count", 4'd4, 32'h0);
    checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R3 irq actual %b expected 0", irq); end

    curReq = "R1";
    rd("R1 unmapped 5", 4'd5, 32'h0);
    rd("R1 unmapped 15", 4'd15, 32'h0);
    wr(4'd4, 32'h1234);
    wr(4'd9, 32'h55);
    rd("R1 count write ignored", 4'd4, 32'h0);
    rd("R1 load untouched", 4'd2, 32'hFFFF_FFFF);
    rd("R1 cmp untouched", 4'd3, 32'h0);

    curReq = "R2";
    wr(4'd0, 32'hFFFE_FFFE);
    rd("R2 upper bits zero", 4'd0, 32'h03FE_FFFE);
    wr(4'd0, 32'h0);

    curReq = "R8";
    wr(4'd2, 32'd20);
    wr(4'd0, C_EN | C_ENMOD | C_RLD | (32'd1 << 24));
    curReq = "R7";
    step(60, 1);

    curReq = "R6";
    wr(4'd0, 32'h0);
    wr(4'd0, C_EN | C_ENMOD | C_RLD | (32'd2 << 24) | (32'd3 << 4));
    step(90, 2);

    curReq = "R5";
    wr(4'd0, C_EN | C_ENMOD | C_RLD | (32'd3 << 24));
    step(60, 2);
    wr(4'd0, C_EN | C_ENMOD | C_RLD);
    step(20, 1);

    curReq = "R8";
    wr(4'd0, 32'h0);
    wr(4'd0, C_EN | C_ENMOD | (32'd1 << 24));
    curReq = "R10";
    wr(4'd0, C_EN | C_ENMOD | C_IOVW | (32'd1 << 24));
    wr(4'd2, 32'd5);
    curReq = "R7";
    step(20, 1);
    curReq = "R10";
    wr(4'd0, C_EN | C_ENMOD | (32'd1 << 24));
    wr(4'd2, 32'd100);
    step(5, 1);
    curReq = "R8";
    wr(4'd0, C_ENMOD | (32'd1 << 24));
    wr(4'd0, C_EN | (32'd1 << 24));
    step(5, 1);

    curReq = "R11";
    wr(4'd0, 32'h0);
    wr(4'd2, 32'd10);
    wr(4'd3, 32'd4);
    wr(4'd0, C_EN | C_ENMOD | C_RLD | C_OCIEN | (32'd1 << 24));
    step(20, 1);
    curReq = "R12";
    wr(4'd1, 32'h0);
    step(2, 0);
    rd("R12 write zero keeps flag", 4'd1, 32'h1);
    wr(4'd1, 32'h1);
    rd("R12 write one clears flag", 4'd1, 32'h0);
    step(25, 1);
    curReq = "R13";
    wr(4'd0, C_EN | C_ENMOD | C_RLD | (32'd1 << 24));
    step(25, 1);
    wr(4'd0, C_EN | C_ENMOD | C_RLD | C_OCIEN | (32'd1 << 24));
    step(3, 1);
    curReq = "R9";
    wr(4'd0, C_ENMOD | C_RLD | C_OCIEN | (32'd1 << 24));
    step(15, 1);

    curReq = "R4";
    wr(4'd0, C_EN | C_ENMOD | C_OCIEN | C_RLD | C_IOVW | C_DBGEN | (32'd1 << 24) | (32'd2 << 4));
    step(20, 1);
    wr(4'd0, C_EN | C_SWR | C_STOPEN | C_RLD | (32'd1 << 24));
    rd("R4 keep mask with EN", 4'd0, 32'h0020_0001);
    rd("R4 count all-ones", 4'd4, 32'hFFFF_FFFF);
    rd("R4 load all-ones", 4'd2, 32'hFFFF_FFFF);
    wr(4'd0, C_SWR | C_ENMOD);
    rd("R4 keep mask without EN", 4'd0, 32'h0000_0002);
    rd("R4 count zero", 4'd4, 32'h0);
    rd("R4 cmp zero", 4'd3, 32'h0);
    step(5, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule